// File: doc/BRIEF.md
# Burn-in Sync and Test Pattern Generator

This block produces a free-running horizontal and vertical sync pair for display burn-in. It needs no incoming video timing. Three timings are available, each a fixed odd number of 8 MHz clocks per line with a fixed number of lines per frame. Two select inputs choose the timing. Each sync output has its own polarity input, which sets whether the sync pulse is driven high or low.

The block also drives a one-bit video signal that is locked to the line and frame counters of whichever timing is selected. It can show an 8×8 cross hatch, an inverted cross hatch, a full white field or a full black field. The active area is the part of each line after the H sync pulse, in every line after the V sync lines. This area is split into eight equal columns and eight equal rows. A vertical grid line is one clock wide and falls on the first clock of each column. A horizontal grid line covers the whole first line of each row. Any remainder from the division goes to the last column or the last row.

Top module: `burnin_sync_gen`

## Requirements
- R1: The line period is LINE_FAST clocks (default 125) when `rate_mid_i`=0 and `rate_hi_i`=1. It is LINE_MID clocks (default 167) whenever `rate_mid_i`=1, whatever `rate_hi_i` is. It is LINE_SLOW clocks (default 257) when both selects are 0.
- R2: The frame holds FRAME_FAST lines (default 1024) in the LINE_FAST timing, FRAME_MID lines (default 640) in the LINE_MID timing and FRAME_SLOW lines (default 512) in the LINE_SLOW timing.
- R3: The H sync is active for the first HS_W clocks of every line (default 16, which is 2 µs) and inactive for the rest of the line.
- R4: The V sync is active for the first VS_LINES lines of every frame (default 4), for the whole of each of those lines.
- R5: A polarity input of 1 makes its sync output high when active and low when inactive. A polarity input of 0 inverts that output.
- R6: After reset, and for as long as `self_en_i`=0, the line and frame counters stay at zero. During that time both syncs sit at their inactive level and `pat_o`=0. Once `self_en_i` goes high, the timing starts from clock 0 of line 0.
- R7: `pat_o` is 0 unless `self_en_i` and `pat_en_i` are both 1.
- R8: `pat_o` is 0 during the H sync clocks of every line and during the V sync lines, whatever the pattern code.
- R9: Pattern code 2'b00 gives a cross hatch. Let c = (LINE−HS_W)/8 and r = (FRAME−VS_LINES)/8, using integer division. `pat_o` is 1 at active clock offsets k·c and in whole active lines at row offsets k·r, for k = 0..7, and 0 elsewhere in the active area.
- R10: Pattern code 2'b01 gives 1 over the whole active area. Pattern code 2'b11 gives 0 everywhere.
- R11: Pattern code 2'b10 gives the complement of the cross hatch inside the active area.
- R12: If a new select makes the line or frame shorter than the current count, that counter wraps to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| self_en_i | input | 1 | Runs the free-running timing |
| pat_en_i | input | 1 | Enables the test pattern output |
| rate_hi_i | input | 1 | Selects the fastest timing when `rate_mid_i` is 0 |
| rate_mid_i | input | 1 | Selects the middle timing (takes priority) |
| pat_sel_i | input | 2 | Pattern code: 00 hatch, 01 white, 10 inverted hatch, 11 black |
| hpol_i | input | 1 | H sync polarity (1 = active high) |
| vpol_i | input | 1 | V sync polarity (1 = active high) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| pat_o | output | 1 | One-bit video test pattern |

## Verification
The bench builds the block with short timings: lines of 25, 33 and 41 clocks, frames of 32, 24 and 20 lines, a 4-clock H sync and 2 V sync lines. The grid count stays at 8. With these values a full frame of every timing, with each of the four patterns and every polarity, fits in a few thousand cycles. The columns are 2, 3 and 4 clocks wide and the rows are 3, 2 and 2 lines high, so the divisions leave remainders. This exercises a last column and a last row that are wider than the others. The shrinking-select wrap and the priority of the middle-rate select are driven on purpose and measured at the ports.

// File: rtl/burnin_pkg.sv
// Shared types for the burn-in sync generator.
// Assumes: three timings, picked by two select bits; the middle-rate select has priority.
package burnin_pkg;

    typedef enum logic [1:0] {
        MODE_FAST = 2'd0,
        MODE_MID  = 2'd1,
        MODE_SLOW = 2'd2
    } rate_mode_e;

    typedef enum logic [1:0] {
        PAT_HATCH = 2'b00,
        PAT_WHITE = 2'b01,
        PAT_INV   = 2'b10,
        PAT_BLACK = 2'b11
    } pat_kind_e;

    // Decode the two rate selects; the middle select wins over the fast select.
    function automatic rate_mode_e pick_mode(input logic sel_mid, input logic sel_hi);
        if (sel_mid)     return MODE_MID;
        else if (sel_hi) return MODE_FAST;
        else             return MODE_SLOW;
    endfunction

endpackage

// File: rtl/bis_timebase.sv
// Line and frame counters for the free-running timing.
// Assumes: last-index inputs may change at any clock; a counter at or past
// its last index wraps to 0 on the next clock. Counters hold at 0 while run_i is low.
module bis_timebase #(
    parameter int HW = 9,
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [HW-1:0] line_last_i,
    input  logic [VW-1:0] frame_last_i,
    output logic [HW-1:0] hcnt_o,
    output logic [VW-1:0] vcnt_o
);

    logic [HW-1:0] hcnt_q;
    logic [VW-1:0] vcnt_q;

    // Advance the clock-in-line counter, and the line counter at each line wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            hcnt_q <= '0;
            vcnt_q <= '0;
        end else if (hcnt_q >= line_last_i) begin
            hcnt_q <= '0;
            if (vcnt_q >= frame_last_i) vcnt_q <= '0;
            else                        vcnt_q <= vcnt_q + VW'(1);
        end else begin
            hcnt_q <= hcnt_q + HW'(1);
        end
    end

    assign hcnt_o = hcnt_q;
    assign vcnt_o = vcnt_q;

    // R1
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && hcnt_q < line_last_i) |=> (hcnt_q == $past(hcnt_q) + HW'(1)));

    // R2
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && hcnt_q < line_last_i) |=> $stable(vcnt_q));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (hcnt_q == '0 && vcnt_q == '0));

endmodule

// File: rtl/bis_pattern.sv
// One-bit test pattern drawn from the line and frame counters.
// Assumes: columns are colw_i clocks wide and rows are rowh_i lines high, both
// at least 1; GRID vertical and GRID horizontal lines; low in blanking.
module bis_pattern
    import burnin_pkg::*;
#(
    parameter int HW       = 9,
    parameter int VW       = 10,
    parameter int GRID     = 8,
    parameter int HS_W     = 16,
    parameter int VS_LINES = 4
) (
    input  logic [HW-1:0] hcnt_i,
    input  logic [VW-1:0] vcnt_i,
    input  logic [HW-1:0] colw_i,
    input  logic [VW-1:0] rowh_i,
    input  logic [1:0]    sel_i,
    input  logic          en_i,
    output logic          pat_o
);

    logic [HW-1:0]   hoff;
    logic [VW-1:0]   voff;
    logic            active;
    logic [GRID-1:0] col_hit;
    logic [GRID-1:0] row_hit;
    logic            grid;

    assign hoff   = hcnt_i - HW'(HS_W);
    assign voff   = vcnt_i - VW'(VS_LINES);
    assign active = (hcnt_i >= HW'(HS_W)) && (vcnt_i >= VW'(VS_LINES));

    // One comparator per grid line, on each axis.
    for (genvar k = 0; k < GRID; k++) begin : g_grid
        localparam logic [HW-1:0] KH = HW'(k);
        localparam logic [VW-1:0] KV = VW'(k);
        assign col_hit[k] = (hoff == KH * colw_i);
        assign row_hit[k] = (voff == KV * rowh_i);
    end

    assign grid = (|col_hit) || (|row_hit);

    // Pick the picture content inside the active area.
    always_comb begin
        pat_o = 1'b0;
        if (en_i && active) begin
            case (pat_kind_e'(sel_i))
                PAT_HATCH: pat_o = grid;
                PAT_WHITE: pat_o = 1'b1;
                PAT_INV:   pat_o = !grid;
                default:   pat_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/burnin_sync_gen.sv
// Burn-in sync and test pattern generator: free-running H/V sync with
// three selectable timings, programmable polarity and a locked test pattern.
// Assumes: HS_W < every line length, VS_LINES < every frame length,
// and each active span is at least GRID units long.
module burnin_sync_gen
    import burnin_pkg::*;
#(
    parameter int LINE_FAST  = 125,
    parameter int LINE_MID   = 167,
    parameter int LINE_SLOW  = 257,
    parameter int FRAME_FAST = 1024,
    parameter int FRAME_MID  = 640,
    parameter int FRAME_SLOW = 512,
    parameter int HS_W       = 16,
    parameter int VS_LINES   = 4,
    parameter int GRID       = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       self_en_i,
    input  logic       pat_en_i,
    input  logic       rate_hi_i,
    input  logic       rate_mid_i,
    input  logic [1:0] pat_sel_i,
    input  logic       hpol_i,
    input  logic       vpol_i,
    output logic       hsync_o,
    output logic       vsync_o,
    output logic       pat_o
);

    localparam int LINE_MAX  = (LINE_FAST > LINE_MID)
                             ? ((LINE_FAST > LINE_SLOW) ? LINE_FAST : LINE_SLOW)
                             : ((LINE_MID > LINE_SLOW) ? LINE_MID : LINE_SLOW);
    localparam int FRAME_MAX = (FRAME_FAST > FRAME_MID)
                             ? ((FRAME_FAST > FRAME_SLOW) ? FRAME_FAST : FRAME_SLOW)
                             : ((FRAME_MID > FRAME_SLOW) ? FRAME_MID : FRAME_SLOW);
    localparam int HW = $clog2(LINE_MAX);
    localparam int VW = $clog2(FRAME_MAX);

    localparam int COLW_FAST = (LINE_FAST - HS_W) / GRID;
    localparam int COLW_MID  = (LINE_MID  - HS_W) / GRID;
    localparam int COLW_SLOW = (LINE_SLOW - HS_W) / GRID;
    localparam int ROWH_FAST = (FRAME_FAST - VS_LINES) / GRID;
    localparam int ROWH_MID  = (FRAME_MID  - VS_LINES) / GRID;
    localparam int ROWH_SLOW = (FRAME_SLOW - VS_LINES) / GRID;

    logic [HW-1:0] line_last;
    logic [VW-1:0] frame_last;
    logic [HW-1:0] colw;
    logic [VW-1:0] rowh;
    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          hs_act;
    logic          vs_act;

    // Map the rate selects onto line/frame limits and grid spacing.
    always_comb begin
        case (pick_mode(rate_mid_i, rate_hi_i))
            MODE_FAST: begin
                line_last  = HW'(LINE_FAST - 1);
                frame_last = VW'(FRAME_FAST - 1);
                colw       = HW'(COLW_FAST);
                rowh       = VW'(ROWH_FAST);
            end
            MODE_MID: begin
                line_last  = HW'(LINE_MID - 1);
                frame_last = VW'(FRAME_MID - 1);
                colw       = HW'(COLW_MID);
                rowh       = VW'(ROWH_MID);
            end
            default: begin
                line_last  = HW'(LINE_SLOW - 1);
                frame_last = VW'(FRAME_SLOW - 1);
                colw       = HW'(COLW_SLOW);
                rowh       = VW'(ROWH_SLOW);
            end
        endcase
    end

    bis_timebase #(.HW(HW), .VW(VW)) u_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (self_en_i),
        .line_last_i  (line_last),
        .frame_last_i (frame_last),
        .hcnt_o       (hcnt),
        .vcnt_o       (vcnt)
    );

    bis_pattern #(
        .HW(HW), .VW(VW), .GRID(GRID), .HS_W(HS_W), .VS_LINES(VS_LINES)
    ) u_pattern (
        .hcnt_i (hcnt),
        .vcnt_i (vcnt),
        .colw_i (colw),
        .rowh_i (rowh),
        .sel_i  (pat_sel_i),
        .en_i   (self_en_i && pat_en_i),
        .pat_o  (pat_o)
    );

    // Sync pulses from the counter windows, then apply the requested polarity.
    assign hs_act  = self_en_i && (hcnt < HW'(HS_W));
    assign vs_act  = self_en_i && (vcnt < VW'(VS_LINES));
    assign hsync_o = !(hs_act ^ hpol_i);
    assign vsync_o = !(vs_act ^ vpol_i);

    // R7
    pattern_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(self_en_i && pat_en_i) |-> !pat_o);

    // R8
    blank_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt < HW'(HS_W) || vcnt < VW'(VS_LINES)) |-> !pat_o);

endmodule

// File: tb/burnin_sync_gen_bench.sv
module burnin_sync_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LF = 25, LM = 33, LS = 41;
    localparam int FF = 32, FM = 24, FS = 20;
    localparam int HSW = 4, VSL = 2, GR = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic self_en = 1'b0, pat_en = 1'b0, rate_hi = 1'b0, rate_mid = 1'b0;
    logic [1:0] pat_sel = 2'b00;
    logic hpol = 1'b1, vpol = 1'b1;
    logic hsync, vsync, pat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int mh = 0, mv = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burnin_sync_gen #(
        .LINE_FAST(LF), .LINE_MID(LM), .LINE_SLOW(LS),
        .FRAME_FAST(FF), .FRAME_MID(FM), .FRAME_SLOW(FS),
        .HS_W(HSW), .VS_LINES(VSL), .GRID(GR)
    ) u_burnin_sync_gen (
        .clk(clk), .rst_n(rst_n), .self_en_i(self_en), .pat_en_i(pat_en),
        .rate_hi_i(rate_hi), .rate_mid_i(rate_mid), .pat_sel_i(pat_sel),
        .hpol_i(hpol), .vpol_i(vpol),
        .hsync_o(hsync), .vsync_o(vsync), .pat_o(pat)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    function automatic int cur_line();
        if (rate_mid) return LM;
        else if (rate_hi) return LF;
        return LS;
    endfunction

    function automatic int cur_frame();
        if (rate_mid) return FM;
        else if (rate_hi) return FF;
        return FS;
    endfunction

    // Behavioural counter model, stepping on every rising edge.
    always @(posedge clk) begin
        if (!rst_n || !self_en) begin
            mh = 0; mv = 0;
        end else if (mh >= cur_line() - 1) begin
            mh = 0;
            if (mv >= cur_frame() - 1) mv = 0; else mv = mv + 1;
        end else begin
            mh = mh + 1;
        end
    end

    // Per-cycle comparison of all three outputs against the model.
    always @(posedge clk) begin
        int cw, rh, hoff, voff;
        bit hs, vs, act, grid, ep;
        #(CLK_PERIOD/4);
        hs = self_en && (mh < HSW);
        vs = self_en && (mv < VSL);
        cw = (cur_line() - HSW) / GR;
        rh = (cur_frame() - VSL) / GR;
        hoff = mh - HSW;
        voff = mv - VSL;
        act = (mh >= HSW) && (mv >= VSL);
        grid = (act && (hoff % cw == 0) && (hoff / cw < GR)) ||
               (act && (voff % rh == 0) && (voff / rh < GR));
        ep = 1'b0;
        if (self_en && pat_en && act) begin
            case (pat_sel)
                2'b00: ep = grid;
                2'b01: ep = 1'b1;
                2'b10: ep = !grid;
                default: ep = 1'b0;
            endcase
        end
        chk(hsync === (hpol ? hs : !hs), "R1 R3 R5 hsync", int'(hsync), int'(hpol ? hs : !hs));
        chk(vsync === (vpol ? vs : !vs), "R2 R4 R5 vsync", int'(vsync), int'(vpol ? vs : !vs));
        chk(pat === ep, "R7 R8 R9 R10 R11 pattern", int'(pat), int'(ep));
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Cycles from one H sync start to the next, sampled at falling edges.
    task automatic meas_line(output int n);
        n = 0;
        while (hsync === hpol) @(negedge clk);
        while (hsync !== hpol) @(negedge clk);
        while (hsync === hpol) begin @(negedge clk); n++; end
        while (hsync !== hpol) begin @(negedge clk); n++; end
    endtask

    // H sync starts counted from one V sync start to the next.
    task automatic meas_frame(output int n);
        bit ph, pv;
        while (vsync === vpol) @(negedge clk);
        while (vsync !== vpol) @(negedge clk);
        n = 1; ph = 1'b1; pv = 1'b1;
        forever begin
            @(negedge clk);
            if (vsync === vpol && !pv) break;
            if (hsync === hpol && !ph) n++;
            ph = (hsync === hpol);
            pv = (vsync === vpol);
        end
    endtask

    task automatic set_rate(input int m);
        case (m)
            0: begin rate_hi = 1'b1; rate_mid = 1'b0; end
            1: begin rate_hi = 1'b0; rate_mid = 1'b1; end
            default: begin rate_hi = 1'b0; rate_mid = 1'b0; end
        endcase
    endtask

    initial begin
        int n;
        step(3);
        // R6: reset state, self mode off
        chk(hsync === 1'b0, "R6 reset hsync", int'(hsync), 0);
        chk(vsync === 1'b0, "R6 reset vsync", int'(vsync), 0);
        chk(pat === 1'b0, "R6 reset pattern", int'(pat), 0);
        rst_n = 1'b1;
        step(2);
        self_en = 1'b1;
        pat_en = 1'b1;
        for (int m = 0; m < 3; m++) begin
            set_rate(m);
            step(2);
            meas_line(n);
            chk(n == cur_line(), "R1 line period", n, cur_line());
            meas_frame(n);
            chk(n == cur_frame(), "R2 frame lines", n, cur_frame());
            for (int p = 0; p < 4; p++) begin
                pat_sel = 2'(p);
                step(cur_line() * cur_frame() + 7);
            end
        end
        // R1: middle select takes priority over the fast select
        rate_hi = 1'b1; rate_mid = 1'b1;
        meas_line(n);
        chk(n == LM, "R1 select priority", n, LM);
        // R5: all polarity combinations
        pat_sel = 2'b00;
        for (int k = 0; k < 4; k++) begin
            hpol = k[0]; vpol = k[1];
            step(LM * 6);
        end
        hpol = 1'b1; vpol = 1'b1;
        // R7: pattern gated off
        pat_en = 1'b0; pat_sel = 2'b01;
        step(LM * FM);
        pat_en = 1'b1;
        // R6: self mode off holds the counters; restart from line 0
        self_en = 1'b0;
        step(50);
        chk(hsync === 1'b0 && vsync === 1'b0, "R6 idle syncs", int'({hsync, vsync}), 0);
        self_en = 1'b1;
        step(LM * FM + 5);
        // R12: shrink the line while the count is beyond the new last index
        set_rate(2);
        step(LS * FS);
        while (mh < LF + 5) @(negedge clk);
        set_rate(0);
        @(negedge clk);
        chk(hsync === hpol, "R12 wrap on shrink", int'(hsync), int'(hpol));
        step(LF * FF * 2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule